// File: doc/BRIEF.md
# Carrier-Keyed Data Signal Modulator

This block keys between two carrier waveforms according to a modulator data stream. While the modulator is high, the output follows the high carrier. While it is low, the output follows the low carrier. A select field picks each of the three signals from its own bank of input lines. One modulator choice is a software data bit. All source lines are already synchronous to the system clock.

Each carrier has its own synchronization option. When the option is set for the carrier that is currently mixed, a modulator transition does not cut that carrier's pulse short. The switch waits until the carrier is low. Without the option, the switch happens on the next clock edge. The block has a module enable and a separate output enable. Clearing the module enable forces the default sources and holds the output low. Clearing the output enable only holds the output low, and the internal carrier tracking goes on.

Top module: `carrier_keyed_modulator`

## Requirements
- R1: While reset is active and right after it, `mod_o` is 0.
- R2: Modulator select `mod_sel_i` picks the modulator as follows.
  - Code 0 picks `sw_bit_i`.
  - Code k in 1..MOD_N picks `mod_src_i[k-1]`.
  - Codes above MOD_N give a constant 0.
- R3: Each carrier select (`carh_sel_i`, `carl_sel_i`) picks a carrier as follows.
  - Code k in 0..CAR_N-1 picks `car_src_i[k]`.
  - Codes CAR_N and above give a constant 0.
- R4: The output is registered, and a carrier switch without synchronization takes one edge.
  - With both enables set, `mod_o` after a clock edge equals the value of the selected carrier in the cycle before that edge.
  - With synchronization off for the carrier being left, a modulator change moves the output to the other carrier at the next edge.
- R5: While `en_i` is 0, `mod_o` is 0.
  - The modulator is forced to `sw_bit_i`.
  - Both carriers are forced to select code 0.
- R6: When `en_i` is set again, the programmed select codes take effect at once. The output at the first edge after enabling reflects them.
- R7: While `out_en_i` is 0, `mod_o` is 0, but the carrier choice keeps following the modulator. After `out_en_i` returns to 1, the output shows the carrier that was tracked meanwhile.
- R8: When `hsync_i` is 1 and the modulator falls while the high carrier is mixed, the output keeps following the high carrier until a cycle in which that carrier is 0. At that point it switches.
- R9: When `lsync_i` is 1 and the modulator rises while the low carrier is mixed, the output keeps following the low carrier until a cycle in which that carrier is 0. The low-carrier setting does not depend on `hsync_i`.
- R10: Suppose the modulator returns to the carrier still in use while a synchronized switch is pending. The pending switch is then dropped, and the output stays on that carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable |
| out_en_i | input | 1 | Output enable |
| sw_bit_i | input | 1 | Software modulator bit |
| mod_sel_i | input | 4 | Modulator source select |
| carh_sel_i | input | 3 | High-carrier source select |
| carl_sel_i | input | 3 | Low-carrier source select |
| hsync_i | input | 1 | Synchronize switches away from the high carrier |
| lsync_i | input | 1 | Synchronize switches away from the low carrier |
| mod_src_i | input | MOD_N (8) | Modulator source lines |
| car_src_i | input | CAR_N (6) | Carrier source lines |
| mod_o | output | 1 | Registered modulated output |

## Verification
A modulator edge and the fall of the carrier that is being left can land in the same cycle. In that case the synchronized switch must happen at once, not one cycle late. The bench provokes this with random carriers and modulators while synchronization is on, and with directed sequences that drop the carrier in the cycle of the modulator change. A second coincidence is a modulator reversal during a pending switch together with a gated output (R7, R10). A requirement-level model in the bench predicts each output, and a scoreboard judges it one edge later.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } sync_cfg_t;
endpackage

// File: rtl/ckm_src_mux.sv
module ckm_src_mux #(
  parameter int N     = 8,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N-1:0]     src_i,
  output logic             y_o
);
  localparam int CODES = 1 << SEL_W;

  logic [CODES-1:0] padded;

  // codes without a line read a constant low
  generate
    for (genvar k = 0; k < CODES; k++) begin : g_pad
      if (k < N) begin : g_line
        assign padded[k] = src_i[k];
      end else begin : g_zero
        assign padded[k] = 1'b0;
      end
    end
  endgenerate

  assign y_o = padded[sel_i];
endmodule

// File: rtl/ckm_switch_ctrl.sv
module ckm_switch_ctrl
  import ckm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mod_i,
  input  logic      car_h_i,
  input  logic      car_l_i,
  input  sync_cfg_t sync_i,
  output logic      sel_hi_nxt_o
);
  logic sel_hi_q;
  logic cur_sync;
  logic cur_car;
  logic hold;

  assign cur_sync = sel_hi_q ? sync_i.hi : sync_i.lo;
  assign cur_car  = sel_hi_q ? car_h_i : car_l_i;
  // a synchronized switch waits while the carrier being left is still high
  assign hold     = cur_sync && cur_car;

  always_comb begin
    sel_hi_nxt_o = sel_hi_q;
    if ((mod_i != sel_hi_q) && !hold) sel_hi_nxt_o = mod_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_hi_q <= 1'b0;
    else         sel_hi_q <= sel_hi_nxt_o;
  end

  // R8
  hi_sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_hi_q && sync_i.hi && car_h_i && !mod_i) |=> sel_hi_q);

  // R9
  lo_sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_hi_q && sync_i.lo && car_l_i && mod_i) |=> !sel_hi_q);

  // R4
  nosync_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mod_i != sel_hi_q) && !(sel_hi_q ? sync_i.hi : sync_i.lo)) |=> (sel_hi_q == $past(mod_i)));

  // R10
  settled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_i == sel_hi_q) |=> $stable(sel_hi_q));
endmodule

// File: rtl/ckm_out_stage.sv
module ckm_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic out_en_i,
  input  logic sel_hi_i,
  input  logic car_h_i,
  input  logic car_l_i,
  output logic mod_o
);
  logic mix;

  assign mix = sel_hi_i ? car_h_i : car_l_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_o <= 1'b0;
    else         mod_o <= en_i && out_en_i && mix;
  end

  // R5
  gate_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || !out_en_i) |=> !mod_o);

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !mod_o);
endmodule

// File: rtl/carrier_keyed_modulator.sv
module carrier_keyed_modulator
  import ckm_pkg::*;
#(
  parameter int MOD_N  = 8,
  parameter int CAR_N  = 6,
  parameter int MSEL_W = 4,
  parameter int CSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              out_en_i,
  input  logic              sw_bit_i,
  input  logic [MSEL_W-1:0] mod_sel_i,
  input  logic [CSEL_W-1:0] carh_sel_i,
  input  logic [CSEL_W-1:0] carl_sel_i,
  input  logic              hsync_i,
  input  logic              lsync_i,
  input  logic [MOD_N-1:0]  mod_src_i,
  input  logic [CAR_N-1:0]  car_src_i,
  output logic              mod_o
);
  localparam int MLINES = MOD_N + 1;

  logic [MSEL_W-1:0] msel_eff;
  logic [CSEL_W-1:0] hsel_eff, lsel_eff;
  logic [MLINES-1:0] mlines;
  logic              mod_val, car_h, car_l, sel_hi_nxt;
  sync_cfg_t         sync_cfg;

  // disabled: defaults (code 0 = software bit / first carrier line)
  assign msel_eff = en_i ? mod_sel_i  : '0;
  assign hsel_eff = en_i ? carh_sel_i : '0;
  assign lsel_eff = en_i ? carl_sel_i : '0;
  assign mlines   = {mod_src_i, sw_bit_i};
  assign sync_cfg = '{hi: hsync_i, lo: lsync_i};

  ckm_src_mux #(.N(MLINES), .SEL_W(MSEL_W)) mod_mux_i (
    .sel_i(msel_eff), .src_i(mlines), .y_o(mod_val)
  );

  ckm_src_mux #(.N(CAR_N), .SEL_W(CSEL_W)) carh_mux_i (
    .sel_i(hsel_eff), .src_i(car_src_i), .y_o(car_h)
  );

  ckm_src_mux #(.N(CAR_N), .SEL_W(CSEL_W)) carl_mux_i (
    .sel_i(lsel_eff), .src_i(car_src_i), .y_o(car_l)
  );

  ckm_switch_ctrl ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mod_i       (mod_val),
    .car_h_i     (car_h),
    .car_l_i     (car_l),
    .sync_i      (sync_cfg),
    .sel_hi_nxt_o(sel_hi_nxt)
  );

  ckm_out_stage out_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .out_en_i(out_en_i),
    .sel_hi_i(sel_hi_nxt),
    .car_h_i (car_h),
    .car_l_i (car_l),
    .mod_o   (mod_o)
  );
endmodule

// File: tb/carrier_keyed_modulator_tb_top.sv
module carrier_keyed_modulator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MOD_N = 8;
  localparam int CAR_N = 6;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, oe = 0, sw = 0, hs = 0, ls = 0;
  logic [3:0] msel = '0;
  logic [2:0] hsel = '0, lsel = '0;
  logic [MOD_N-1:0] msrc = '0;
  logic [CAR_N-1:0] csrc = '0;
  logic mod_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic m_sel = 1'b0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_keyed_modulator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .out_en_i(oe), .sw_bit_i(sw),
    .mod_sel_i(msel), .carh_sel_i(hsel), .carl_sel_i(lsel),
    .hsync_i(hs), .lsync_i(ls), .mod_src_i(msrc), .car_src_i(csrc), .mod_o(mod_o)
  );

  function automatic logic pick_car(input logic [2:0] s);
    if (!en) return csrc[0];
    if (int'(s) < CAR_N) return csrc[s];
    return 1'b0;
  endfunction

  function automatic logic pick_mod();
    int k = int'(msel);
    if (!en || k == 0) return sw;
    if (k <= MOD_N) return msrc[k-1];
    return 1'b0;
  endfunction

  // driver: inputs already set at a negedge; model the edge, queue the result
  task automatic cycle(input string tag);
    logic mv, ch, cl, cur_s, cur_c, nxt;
    item_t it;
    mv = pick_mod();
    ch = pick_car(hsel);
    cl = pick_car(lsel);
    cur_s = m_sel ? hs : ls;
    cur_c = m_sel ? ch : cl;
    nxt = m_sel;
    if (mv != m_sel && !(cur_s && cur_c)) nxt = mv;
    it.exp = en && oe && (nxt ? ch : cl);
    it.tag = tag;
    m_sel = nxt;
    @(posedge clk);
    #1;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (mod_o !== it.exp) begin
        fails++;
        $display("FAIL %s: mod_o=%b expected=%b at %0t", it.tag, mod_o, it.exp, $time);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    // R1
    repeat (3) @(negedge clk);
    checks++;
    if (mod_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: mod_o=%b expected=0", mod_o);
    end
    rst_n = 1'b1;
    cycle("R1");

    // R2: high carrier constant 1, low carrier constant 0 -> output = modulator
    en = 1; oe = 1; hsel = 3'd0; lsel = 3'd1; csrc = 6'b000001;
    for (int s = 0; s < 16; s++) begin
      msel = 4'(s);
      for (int r = 0; r < 6; r++) begin
        sw = $urandom_range(0, 1);
        msrc = 8'($urandom);
        cycle("R2");
      end
    end

    // R3: sweep both carrier selects with random lines
    msel = 4'd0;
    for (int s = 0; s < 8; s++) begin
      hsel = 3'(s); lsel = 3'(7 - s);
      for (int r = 0; r < 6; r++) begin
        sw = $urandom_range(0, 1);
        csrc = 6'($urandom);
        cycle("R3");
      end
    end

    // R4: random mixing, no sync
    msel = 4'd3; hsel = 3'd2; lsel = 3'd4;
    for (int r = 0; r < 200; r++) begin
      msrc = 8'($urandom); csrc = 6'($urandom);
      cycle("R4");
    end

    // R8 directed: leave the high carrier while it is still high
    hs = 1; ls = 0; msel = 4'd0; hsel = 3'd0; lsel = 3'd1;
    sw = 1; csrc = 6'b000001; cycle("R8");
    sw = 0; cycle("R8");
    cycle("R8");
    csrc = 6'b000010; cycle("R8");
    cycle("R8");

    // R9 directed: low sync, and coincident edge with carrier low
    hs = 0; ls = 1;
    sw = 1; csrc = 6'b000010; cycle("R9");
    cycle("R9");
    csrc = 6'b000001; cycle("R9");
    sw = 0; csrc = 6'b000000; cycle("R9");
    sw = 1; cycle("R9");

    // R10: reversal while a synchronized switch is pending
    hs = 1; ls = 1; csrc = 6'b000011;
    cycle("R10");
    sw = 0; cycle("R10");
    sw = 1; cycle("R10");
    csrc = 6'b000000; cycle("R10");
    csrc = 6'b000011; cycle("R10");

    // R8/R9 random with sync combinations
    msel = 4'd5; hsel = 3'd1; lsel = 3'd3;
    for (int r = 0; r < 400; r++) begin
      if (r % 100 == 0) begin hs = r[8]; ls = r[7] ^ r[8]; end
      msrc = 8'($urandom); csrc = 6'($urandom);
      cycle(hs ? "R8" : "R9");
    end

    // R7: output gating while tracking continues
    hs = 1; ls = 0;
    for (int r = 0; r < 200; r++) begin
      oe = ($urandom_range(0, 3) != 0);
      msrc = 8'($urandom); csrc = 6'($urandom);
      cycle("R7");
    end
    oe = 1;

    // R5/R6: module enable toggling with programmed selects
    for (int r = 0; r < 200; r++) begin
      en = ($urandom_range(0, 2) != 0);
      sw = $urandom_range(0, 1);
      msrc = 8'($urandom); csrc = 6'($urandom);
      cycle(en ? "R6" : "R5");
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule